// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a 32-bit processor core and a data memory that is one 32-bit word wide and addressed by byte. On every request it forms the effective address from a base register and a signed 16-bit displacement. It drives the memory with the word-aligned address, a four-bit lane-enable mask and a write word in which the store data already sits in the right lanes. Lanes follow big-endian order: the byte at offset 0 inside a word is the most significant one.

For loads the block remembers the access width, the signedness and the byte offset at the moment the request is issued. The memory answers one cycle later. The block then picks the addressed byte or halfword out of the returned word and widens it to 32 bits, by sign extension or by zero extension.

An access whose width does not fit its address raises a misalignment flag. Such an access enables no lanes and issues neither a read nor a write. Trapping on that flag is left to the core.

Top module: `be_lane_aligner`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to 32 bits. `mem_addr` is that address with bits 1..0 forced to zero.
- R2: `mem_wdata` carries the low byte of `req_wdata` copied into all four lanes for a byte access (`req_size` 2'b00). It carries the low halfword copied into both halves for a halfword access (2'b01). It carries the whole of `req_wdata` otherwise.
- R3: While `req_valid` is high and the access is aligned, `mem_be` follows big-endian lane order, with `mem_be[3]` the lane for data bits 31..24. A byte at offset k sets only `mem_be[3-k]`. A halfword gives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word (2'b10) gives 4'b1111. With `req_valid` low, `mem_be` is 0.
- R4: `misalign` is high when `req_valid` is high and one of these holds: the access is a halfword with address bit 0 set, the access is a word with either of address bits 1..0 set, or `req_size` is the reserved code 2'b11.
- R5: On a misaligned access `mem_be` is 4'b0000, and `mem_we` and `mem_re` are both low.
- R6: `mem_we` is high for a valid, aligned request with `req_store` = 1. `mem_re` is high for a valid, aligned request with `req_store` = 0. The two are never high together.
- R7: For a byte load, `ld_data` holds the returned byte at the captured offset: offset 0 is `mem_rdata[31:24]` and offset 3 is `mem_rdata[7:0]`. It is sign-extended when `req_unsigned` was 0 and zero-extended when it was 1.
- R8: For a halfword load, `ld_data` holds `mem_rdata[31:16]` at offset 0 or `mem_rdata[15:0]` at offset 2, extended in the same way as in R7. A word load returns `mem_rdata` unchanged.
- R9: `ld_valid` is high in exactly the cycle after a cycle with `mem_re` high. `ld_data` in that cycle depends only on the captured width, signedness and offset and on `mem_rdata`, not on the request inputs of that cycle.
- R10: After reset `ld_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Load widening: 1 = zero-extend, 0 = sign-extend |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lane enables, bit 3 = bits 31..24 |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 32 | Lane-positioned store data |
| misalign | output | 1 | Access width does not fit its address |
| mem_rdata | input | 32 | Memory read word, valid the cycle after `mem_re` |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result |

## Verification
The bench drives every byte offset and both halfword offsets. It uses load data whose selected byte or halfword has the top bit set and data where it is clear. A design with little-endian lane order would enable the mirrored lane and return the wrong byte. A design that ignores signedness would return the wrong upper bits in one of the two cases.

A negative displacement checks sign extension of the immediate; a design that zero-extends it would land 64 KiB away. Misaligned halfword and word accesses, and the reserved size code, must leave the lanes and strobes quiet; a design that gets this wrong would corrupt memory. A store issued in the cycle a load returns checks that the result is built from the captured load settings; a design that reads the live request inputs would apply the store's width and offset to the returning word.

// File: rtl/be_lane_aligner.sv
module be_lane_aligner #(
  parameter int IMM_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic [31:0] req_base,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [31:0] req_wdata,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic        mem_we,
  output logic        mem_re,
  output logic [31:0] mem_wdata,
  output logic        misalign,
  input  logic [31:0] mem_rdata,
  output logic        ld_valid,
  output logic [31:0] ld_data
);
  localparam int EXT_W = 32 - IMM_W;

  logic [31:0] ea;
  logic [1:0]  off;
  logic [3:0]  lanes;
  logic        bad;

  assign ea       = req_base + {{EXT_W{req_imm[IMM_W-1]}}, req_imm};
  assign off      = ea[1:0];
  assign mem_addr = {ea[31:2], 2'b00};

  always_comb begin
    case (req_size)
      2'b00:   begin lanes = 4'b1000 >> off;                  bad = 1'b0;    end
      2'b01:   begin lanes = off[1] ? 4'b0011 : 4'b1100;      bad = off[0];  end
      2'b10:   begin lanes = 4'b1111;                          bad = |off;    end
      default: begin lanes = 4'b0000;                          bad = 1'b1;    end
    endcase
  end

  assign misalign = req_valid & bad;
  assign mem_be   = (req_valid && !bad) ? lanes : 4'b0000;
  assign mem_we   = req_valid & ~bad & req_store;
  assign mem_re   = req_valid & ~bad & ~req_store;

  always_comb begin
    case (req_size)
      2'b00:   mem_wdata = {4{req_wdata[7:0]}};
      2'b01:   mem_wdata = {2{req_wdata[15:0]}};
      default: mem_wdata = req_wdata;
    endcase
  end

  logic       ld_pend;
  logic [1:0] ld_size;
  logic       ld_uns;
  logic [1:0] ld_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pend <= 1'b0;
      ld_size <= 2'b00;
      ld_uns  <= 1'b0;
      ld_off  <= 2'b00;
    end else begin
      ld_pend <= mem_re;
      if (mem_re) begin
        ld_size <= req_size;
        ld_uns  <= req_unsigned;
        ld_off  <= off;
      end
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    case (ld_off)
      2'd0:    sel_b = mem_rdata[31:24];
      2'd1:    sel_b = mem_rdata[23:16];
      2'd2:    sel_b = mem_rdata[15:8];
      default: sel_b = mem_rdata[7:0];
    endcase
  end

  assign sel_h = ld_off[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (ld_size)
      2'b00:   ld_data = {{24{~ld_uns & sel_b[7]}}, sel_b};
      2'b01:   ld_data = {{16{~ld_uns & sel_h[15]}}, sel_h};
      default: ld_data = mem_rdata;
    endcase
  end

  assign ld_valid = ld_pend;

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |-> ($countones(mem_be) == 1 && !misalign)); // R3
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b01 && !misalign) |-> (mem_be == 4'b1100 || mem_be == 4'b0011)); // R3
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_we && !mem_re)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R6
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ld_valid); // R9
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> !ld_valid); // R9
endmodule

// File: tb/be_lane_aligner_tb.sv
module be_lane_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_base = '0, req_wdata = '0, mem_rdata = '0;
  logic [15:0] req_imm = '0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re, misalign, ld_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  be_lane_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .misalign(misalign),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  localparam logic [31:0] RD = 32'h81F2_637E;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        uns;
    logic [31:0] base;
    logic [15:0] imm;
    logic [31:0] wd;
    logic [31:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wdata;
    logic        e_mis;
    logic [31:0] e_ld;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 1'b0, 32'h1000_0000, 16'h0008, 32'hDEAD_BEEF, 32'h1000_0008, 4'hF, 32'hDEAD_BEEF, 1'b0, 32'h0},
    '{1'b1, 2'd1, 1'b0, 32'h2000_0010, 16'hFFFE, 32'h1234_5678, 32'h2000_000C, 4'h3, 32'h5678_5678, 1'b0, 32'h0},
    '{1'b1, 2'd0, 1'b0, 32'h0000_0300, 16'h0001, 32'hAABB_CC99, 32'h0000_0300, 4'h4, 32'h9999_9999, 1'b0, 32'h0},
    '{1'b1, 2'd0, 1'b0, 32'h0000_0000, 16'h0003, 32'h0000_0042, 32'h0000_0000, 4'h1, 32'h4242_4242, 1'b0, 32'h0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_0401, 16'h0000, 32'h0000_BEEF, 32'h0000_0400, 4'h0, 32'hBEEF_BEEF, 1'b1, 32'h0},
    '{1'b1, 2'd2, 1'b0, 32'h0000_0000, 16'h8000, 32'h0000_0000, 32'hFFFF_8000, 4'hF, 32'h0000_0000, 1'b0, 32'h0},
    '{1'b1, 2'd3, 1'b0, 32'h0000_0900, 16'h0000, 32'h1122_3344, 32'h0000_0900, 4'h0, 32'h1122_3344, 1'b1, 32'h0},
    '{1'b0, 2'd2, 1'b0, 32'h0000_0500, 16'h0004, 32'h0, 32'h0000_0504, 4'hF, 32'h0, 1'b0, 32'h81F2_637E},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0600, 16'h0000, 32'h0, 32'h0000_0600, 4'h8, 32'h0, 1'b0, 32'hFFFF_FF81},
    '{1'b0, 2'd0, 1'b1, 32'h0000_0600, 16'h0000, 32'h0, 32'h0000_0600, 4'h8, 32'h0, 1'b0, 32'h0000_0081},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0603, 16'h0000, 32'h0, 32'h0000_0600, 4'h1, 32'h0, 1'b0, 32'h0000_007E},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0601, 16'h0000, 32'h0, 32'h0000_0600, 4'h4, 32'h0, 1'b0, 32'hFFFF_FFF2},
    '{1'b0, 2'd0, 1'b1, 32'h0000_0602, 16'h0000, 32'h0, 32'h0000_0600, 4'h2, 32'h0, 1'b0, 32'h0000_0063},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0700, 16'h0000, 32'h0, 32'h0000_0700, 4'hC, 32'h0, 1'b0, 32'hFFFF_81F2},
    '{1'b0, 2'd1, 1'b1, 32'h0000_0702, 16'h0000, 32'h0, 32'h0000_0700, 4'h3, 32'h0, 1'b0, 32'h0000_637E},
    '{1'b0, 2'd1, 1'b1, 32'h0000_0700, 16'h0000, 32'h0, 32'h0000_0700, 4'hC, 32'h0, 1'b0, 32'h0000_81F2},
    '{1'b0, 2'd2, 1'b0, 32'h0000_0802, 16'h0000, 32'h0, 32'h0000_0800, 4'h0, 32'h0, 1'b1, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [15:0] imm, input logic [31:0] wd);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_base = base; req_imm = imm; req_wdata = wd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk("R10 ld_valid after reset", {31'b0, ld_valid}, 32'h0);
    chk("R3 mem_be idle", {28'b0, mem_be}, 32'h0);
    chk("R6 strobes idle", {30'b0, mem_we, mem_re}, 32'h0);
    chk("R4 misalign idle", {31'b0, misalign}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].st, VEC[i].sz, VEC[i].uns, VEC[i].base, VEC[i].imm, VEC[i].wd);
      #5;
      chk($sformatf("R1 addr vec%0d", i), mem_addr, VEC[i].e_addr);
      chk(VEC[i].e_mis ? $sformatf("R5 be vec%0d", i) : $sformatf("R3 be vec%0d", i),
          {28'b0, mem_be}, {28'b0, VEC[i].e_be});
      chk($sformatf("R2 wdata vec%0d", i), mem_wdata, VEC[i].e_wdata);
      chk($sformatf("R4 misalign vec%0d", i), {31'b0, misalign}, {31'b0, VEC[i].e_mis});
      chk($sformatf("R6 we/re vec%0d", i), {30'b0, mem_we, mem_re},
          {30'b0, VEC[i].st & ~VEC[i].e_mis, ~VEC[i].st & ~VEC[i].e_mis});
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = RD;
      #5;
      chk($sformatf("R9 ld_valid vec%0d", i), {31'b0, ld_valid}, {31'b0, ~VEC[i].st & ~VEC[i].e_mis});
      if (!VEC[i].st && !VEC[i].e_mis)
        chk(VEC[i].sz == 2'd0 ? $sformatf("R7 ld_data vec%0d", i) : $sformatf("R8 ld_data vec%0d", i),
            ld_data, VEC[i].e_ld);
    end

    // R9: a new store in the return cycle must not disturb the load result
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 32'h0000_0600, 16'h0000, 32'h0);
    @(negedge clk);
    drive(1'b1, 2'd1, 1'b1, 32'h0000_0A02, 16'h0000, 32'h0000_0055);
    mem_rdata = RD;
    #5;
    chk("R9 ld_valid under new request", {31'b0, ld_valid}, 32'h1);
    chk("R9 ld_data uses captured settings", ld_data, 32'hFFFF_FF81);
    chk("R6 store strobe during return", {30'b0, mem_we, mem_re}, 32'h2);
    @(negedge clk);
    req_valid = 1'b0;
    #5;
    chk("R9 no result after store", {31'b0, ld_valid}, 32'h0);

    // R5: misaligned load leaves no result behind
    @(negedge clk);
    drive(1'b0, 2'd1, 1'b0, 32'h0000_0703, 16'h0000, 32'h0);
    #5;
    chk("R5 misaligned half load be", {28'b0, mem_be}, 32'h0);
    chk("R5 misaligned half load strobes", {30'b0, mem_we, mem_re}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    #5;
    chk("R5 no result after misaligned load", {31'b0, ld_valid}, 32'h0);

    // R10: reset drops a pending result
    @(negedge clk);
    drive(1'b0, 2'd2, 1'b0, 32'h0000_0100, 16'h0000, 32'h0);
    @(posedge clk);
    #2;
    req_valid = 1'b0;
    rst_n = 1'b0;
    #3;
    chk("R10 reset clears pending result", {31'b0, ld_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule